// File: doc/BRIEF.md
# Low-Power DRAM Command Legality Tracker

This block sits on the controller side of an eight-bank low-power DRAM channel. It watches every command the controller issues and decides whether that command is legal given what the device is doing. For each bank it keeps a state: idle, open, bursting a read or a write (with or without auto-precharge), or closing. For the device as a whole it keeps one mode: normal, refreshing, power-down, self refresh, deep power-down, command-bus training or write-leveling training.

Each command arrives as a decoded opcode with a bank number, the two highest row bits and a small argument field that selects the kind of mode-register write. One cycle later the tracker gives either an accept pulse or an error pulse with a cause code. Accepted commands update the tracked state, and rejected ones leave it unchanged. The bank states and the device mode are visible on the outputs at all times. AC timing values and the data path are not checked.

Top module: `lpCmdTracker`

## Requirements
- R1: After reset every bank is idle (state code 0), the device mode is normal (mode code 0), and `cmdAccept`, `errValid` and `errCode` are 0. Bank states: 0 idle, 1 open, 2 read burst, 3 write burst, 4 read burst with auto-precharge, 5 write burst with auto-precharge, 6 closing. Each bank occupies 3 bits of `bankState`, with bank b at bits [3b+2:3b]. Opcodes: 0 NOP, 1 activate, 2 read, 3 write, 4 read+AP, 5 write+AP, 6 precharge, 7 precharge all, 8 refresh, 9 self-refresh entry, 10 power-down entry, 11 deep power-down entry, 12 low-power exit, 13 mode-register write, 14 mode-register read, 15 reserved (handled like NOP).
- R2: In normal mode an activate to an idle bank is accepted and the bank becomes open. An activate to a bank that is open or closing is rejected with code 2 (wrong state).
- R3: A read or write of any kind to a bank that is idle or closing is rejected with code 1 (bank not open).
- R4: A read or write accepted on an open bank holds that bank in its burst state for exactly BURST_CYC (default 4) cycles. A bank-specific command to a bursting bank is rejected with code 3 (burst in progress). Precharge-all and power-down entry are also rejected with code 3 while any bank is bursting.
- R5: A burst with auto-precharge is followed by one cycle in the closing state, and then the bank is idle without any further command.
- R6: An activate whose row-top field is 2'b11 is accepted but leaves the bank idle. A write (with or without AP) whose row-top field is 2'b11 is accepted but leaves the bank open and starts no burst.
- R7: Refresh, self-refresh entry, deep power-down entry, mode-register read and mode-register write are accepted only in normal mode with every bank idle. Otherwise they are rejected with code 2. Refresh keeps the device in mode 1 for REF_CYC (default 8) cycles, during which every command other than NOP is rejected with code 2.
- R8: A mode-register write with argument 1 enters command-bus training (mode 5), and one with argument 2 enters write-leveling training (mode 6). The mode is held until the next mode-register write, which returns the device to normal. Every other command except NOP is rejected with code 4 (training active).
- R9: Power-down entry (mode 2) is accepted with banks open, as long as no bank is bursting. Self refresh is mode 3 and deep power-down is mode 4. In these three modes only the low-power exit is accepted, and it returns the device to normal with the bank states kept. Any other command is rejected with code 2. A low-power exit issued in normal mode is rejected with code 2.
- R10: A mode-register write with argument 3 is a device reset. Like other mode-register writes it is accepted only when the device is idle, and it leaves all banks idle and the device in normal mode.
- R11: Every command with `cmdValid` high produces, on the next cycle, exactly one of a one-cycle `cmdAccept` pulse or a one-cycle `errValid` pulse with a non-zero code. A cycle with no command produces neither. NOP is always accepted.
- R12: A precharge to an open bank is accepted and the bank becomes idle on the next cycle. A precharge to an idle bank is accepted with no change. Precharge-all closes every open bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 4 | Decoded opcode (encoding in R1) |
| cmdBank | input | 3 | Target bank |
| cmdRowTop | input | 2 | Two highest row address bits |
| cmdArg | input | 2 | Mode-register write kind: 0 plain, 1 bus training, 2 write leveling, 3 reset |
| cmdAccept | output | 1 | Command of the previous cycle was accepted |
| errValid | output | 1 | Command of the previous cycle was rejected |
| errCode | output | 3 | Rejection cause: 1 not open, 2 wrong state, 3 burst busy, 4 training |
| devMode | output | 3 | Device mode code |
| bankState | output | 24 | Packed per-bank state codes |

## Verification
The bench looks for edge cases at the end of a burst. It issues a precharge one cycle into a read and samples the bank in the last burst cycle and in the first cycle after it. A counter that is off by one moves the bank to open a cycle early or late, and a tracker that lets a burst be cut short accepts the precharge. In the auto-precharge case the bench samples the single closing cycle between the burst and idle. The bench also sends activates and writes into the unpopulated row region, which an incorrect tracker would record as opening a bank or starting a burst. It covers training modes that must persist through idle cycles, and refresh windows whose last cycle must still reject commands.

// File: rtl/lpTrkPkg.sv
package lpTrkPkg;
  localparam int NUM_BANKS = 8;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int ST_W      = 3;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_ACT = 4'd1, OP_RD = 4'd2, OP_WR = 4'd3,
    OP_RDA = 4'd4, OP_WRA = 4'd5, OP_PRE = 4'd6, OP_PREA = 4'd7,
    OP_REF = 4'd8, OP_SREF = 4'd9, OP_PD = 4'd10, OP_DPD = 4'd11,
    OP_EXIT = 4'd12, OP_MRW = 4'd13, OP_MRR = 4'd14, OP_RSVD = 4'd15
  } cmdOp_e;

  typedef enum logic [ST_W-1:0] {
    BK_IDLE = 3'd0, BK_OPEN = 3'd1, BK_RD = 3'd2, BK_WR = 3'd3,
    BK_RDA = 3'd4, BK_WRA = 3'd5, BK_CLOSING = 3'd6
  } bankSt_e;

  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0, MD_REFRESH = 3'd1, MD_PDOWN = 3'd2, MD_SELFREF = 3'd3,
    MD_DEEPPD = 3'd4, MD_TRAINCA = 3'd5, MD_TRAINWL = 3'd6
  } devMode_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_NOTOPEN = 3'd1, ERR_STATE = 3'd2,
    ERR_BURST = 3'd3, ERR_TRAIN = 3'd4
  } errCode_e;

  typedef struct packed {
    logic              act;
    logic              rd;
    logic              wr;
    logic              autoPre;
    logic              pre;
    logic              preAll;
    logic [BANK_W-1:0] bank;
  } bankStb_t;
endpackage

// File: rtl/trkCtrl.sv
module trkCtrl
  import lpTrkPkg::*;
#(
  parameter int REF_CYC = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  input  logic [3:0]                    cmdOp,
  input  logic [BANK_W-1:0]             cmdBank,
  input  logic [1:0]                    cmdRowTop,
  input  logic [1:0]                    cmdArg,
  input  bankSt_e [NUM_BANKS-1:0]       bankSt,
  output bankStb_t                      stb,
  output devMode_e                      devMode,
  output logic                          cmdAccept,
  output logic                          errValid,
  output errCode_e                      errCode
);
  localparam int RC_W = $clog2(REF_CYC + 1);

  cmdOp_e   op;
  bankSt_e  selSt;
  logic     selBusy, anyBusy, allIdle, hiRow, isWr;
  errCode_e err;
  devMode_e modeNxt;
  logic [RC_W-1:0] refCnt;

  assign op    = cmdOp_e'(cmdOp);
  assign selSt = bankSt[cmdBank];
  assign hiRow = &cmdRowTop;
  assign isWr  = (op == OP_WR) || (op == OP_WRA);

  function automatic logic stBusy(input bankSt_e s);
    return (s == BK_RD) || (s == BK_WR) || (s == BK_RDA) || (s == BK_WRA);
  endfunction

  always_comb begin
    anyBusy = 1'b0;
    allIdle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (stBusy(bankSt[b])) anyBusy = 1'b1;
      if (bankSt[b] != BK_IDLE) allIdle = 1'b0;
    end
  end
  assign selBusy = stBusy(selSt);

  always_comb begin
    err     = ERR_NONE;
    stb     = '0;
    stb.bank = cmdBank;
    modeNxt = devMode;
    if (cmdValid && op != OP_NOP && op != OP_RSVD) begin
      case (devMode)
        MD_TRAINCA, MD_TRAINWL: begin
          if (op == OP_MRW) modeNxt = MD_NORMAL;
          else err = ERR_TRAIN;
        end
        MD_REFRESH: err = ERR_STATE;
        MD_PDOWN, MD_SELFREF, MD_DEEPPD: begin
          if (op == OP_EXIT) modeNxt = MD_NORMAL;
          else err = ERR_STATE;
        end
        default: begin
          case (op)
            OP_ACT: begin
              if (selBusy) err = ERR_BURST;
              else if (selSt != BK_IDLE) err = ERR_STATE;
              else if (!hiRow) stb.act = 1'b1;
            end
            OP_RD, OP_WR, OP_RDA, OP_WRA: begin
              if (selBusy) err = ERR_BURST;
              else if (selSt != BK_OPEN) err = ERR_NOTOPEN;
              else if (!(isWr && hiRow)) begin
                stb.rd      = !isWr;
                stb.wr      = isWr;
                stb.autoPre = (op == OP_RDA) || (op == OP_WRA);
              end
            end
            OP_PRE: begin
              if (selBusy) err = ERR_BURST;
              else if (selSt == BK_OPEN) stb.pre = 1'b1;
            end
            OP_PREA: begin
              if (anyBusy) err = ERR_BURST;
              else stb.preAll = 1'b1;
            end
            OP_PD: begin
              if (anyBusy) err = ERR_BURST;
              else modeNxt = MD_PDOWN;
            end
            OP_EXIT: err = ERR_STATE;
            OP_REF, OP_SREF, OP_DPD, OP_MRR, OP_MRW: begin
              if (!allIdle) err = ERR_STATE;
              else if (op == OP_REF) modeNxt = MD_REFRESH;
              else if (op == OP_SREF) modeNxt = MD_SELFREF;
              else if (op == OP_DPD) modeNxt = MD_DEEPPD;
              else if (op == OP_MRW) begin
                case (cmdArg)
                  2'd1: modeNxt = MD_TRAINCA;
                  2'd2: modeNxt = MD_TRAINWL;
                  2'd3: stb.preAll = 1'b1;
                  default: ;
                endcase
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devMode   <= MD_NORMAL;
      refCnt    <= '0;
      cmdAccept <= 1'b0;
      errValid  <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      if (devMode == MD_REFRESH) begin
        if (refCnt == '0) devMode <= MD_NORMAL;
        else refCnt <= refCnt - 1'b1;
      end else begin
        devMode <= modeNxt;
        if (modeNxt == MD_REFRESH) refCnt <= RC_W'(REF_CYC - 1);
      end
      cmdAccept <= cmdValid && (err == ERR_NONE);
      errValid  <= cmdValid && (err != ERR_NONE);
      errCode   <= cmdValid ? err : ERR_NONE;
    end
  end
endmodule

// File: rtl/trkBanks.sv
module trkBanks
  import lpTrkPkg::*;
#(
  parameter int BURST_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bankStb_t                stb,
  output bankSt_e [NUM_BANKS-1:0] bankSt
);
  localparam int CNT_W = $clog2(BURST_CYC + 1);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gBank
    logic [CNT_W-1:0] cnt;
    logic             hit;
    assign hit = (stb.bank == BANK_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankSt[i] <= BK_IDLE;
        cnt       <= '0;
      end else begin
        case (bankSt[i])
          BK_IDLE: begin
            if (stb.act && hit) bankSt[i] <= BK_OPEN;
          end
          BK_OPEN: begin
            if ((stb.rd || stb.wr) && hit) begin
              cnt <= CNT_W'(BURST_CYC - 1);
              if (stb.rd) bankSt[i] <= stb.autoPre ? BK_RDA : BK_RD;
              else        bankSt[i] <= stb.autoPre ? BK_WRA : BK_WR;
            end else if ((stb.pre && hit) || stb.preAll) begin
              bankSt[i] <= BK_IDLE;
            end
          end
          BK_RD, BK_WR, BK_RDA, BK_WRA: begin
            if (cnt == '0) begin
              bankSt[i] <= (bankSt[i] == BK_RDA || bankSt[i] == BK_WRA)
                           ? BK_CLOSING : BK_OPEN;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: bankSt[i] <= BK_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpCmdTracker.sv
module lpCmdTracker
  import lpTrkPkg::*;
#(
  parameter int BURST_CYC = 4,
  parameter int REF_CYC   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  input  logic [3:0]                    cmdOp,
  input  logic [BANK_W-1:0]             cmdBank,
  input  logic [1:0]                    cmdRowTop,
  input  logic [1:0]                    cmdArg,
  output logic                          cmdAccept,
  output logic                          errValid,
  output logic [2:0]                    errCode,
  output logic [2:0]                    devMode,
  output logic [NUM_BANKS*ST_W-1:0]     bankState
);
  bankStb_t                stb;
  bankSt_e [NUM_BANKS-1:0] bankSt;
  devMode_e                modeQ;
  errCode_e                errQ;

  trkCtrl #(.REF_CYC(REF_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdRowTop(cmdRowTop), .cmdArg(cmdArg),
    .bankSt(bankSt), .stb(stb), .devMode(modeQ),
    .cmdAccept(cmdAccept), .errValid(errValid), .errCode(errQ)
  );

  trkBanks #(.BURST_CYC(BURST_CYC)) u_banks (
    .clk(clk), .rstN(rstN), .stb(stb), .bankSt(bankSt)
  );

  assign devMode   = modeQ;
  assign errCode   = errQ;
  assign bankState = bankSt;
endmodule

// File: rtl/lpCmdTrackerChk.sv
module lpCmdTrackerChk
  import lpTrkPkg::*;
#(
  parameter int BURST_CYC = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      cmdValid,
  input logic [3:0]                cmdOp,
  input logic [BANK_W-1:0]         cmdBank,
  input logic                      cmdAccept,
  input logic                      errValid,
  input logic [2:0]                errCode,
  input logic [2:0]                devMode,
  input logic [NUM_BANKS*ST_W-1:0] bankState
);
  logic [NUM_BANKS-1:0] busy;
  logic                 allIdle;
  logic [ST_W-1:0]      selSt;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : gBusy
    assign busy[i] = (bankState[i*ST_W +: ST_W] >= 3'd2) &&
                     (bankState[i*ST_W +: ST_W] <= 3'd5);
  end
  assign allIdle = (bankState == '0);
  assign selSt   = bankState[cmdBank*ST_W +: ST_W];

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (cmdAccept ^ errValid)); // R11
  AST_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (!cmdAccept && !errValid)); // R11
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errCode != 3'd0)); // R11
  AST_READ_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && devMode == 3'd0 && cmdOp == 4'd2 && selSt == 3'd0)
      |=> (errValid && errCode == 3'd1)); // R3
  AST_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((devMode == 3'd5 || devMode == 3'd6) && !(cmdValid && cmdOp == 4'd13))
      |=> $stable(devMode)); // R8
  AST_QUIET_BANKS: assert property (@(posedge clk) disable iff (!rstN)
    (devMode == 3'd1 || devMode == 3'd3 || devMode == 3'd4 ||
     devMode == 3'd5 || devMode == 3'd6) |-> allIdle); // R7

  if (BURST_CYC == 4) begin : gBurst
    for (genvar i = 0; i < NUM_BANKS; i++) begin : gB
      AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rstN)
        $rose(busy[i]) |=> busy[i] ##1 busy[i] ##1 busy[i] ##1 !busy[i]); // R4
    end
  end
endmodule

bind lpCmdTracker lpCmdTrackerChk #(.BURST_CYC(BURST_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdBank(cmdBank), .cmdAccept(cmdAccept), .errValid(errValid),
  .errCode(errCode), .devMode(devMode), .bankState(bankState)
);

// File: tb/lpCmdTracker_bench.sv
module lpCmdTracker_bench;
  localparam logic [3:0] NOP = 0, ACT = 1, RD = 2, WR = 3, RDA = 4, WRA = 5,
    PRE = 6, PREA = 7, REF = 8, SREF = 9, PD = 10, DPD = 11, EXIT = 12,
    MRW = 13, MRR = 14;
  localparam int IDLE = 0, OPEN = 1, SRD = 2, SWRA = 5, CLOSING = 6;

  logic clk = 0, rstN = 0, cmdValid = 0;
  logic [3:0] cmdOp = 0;
  logic [2:0] cmdBank = 0;
  logic [1:0] cmdRowTop = 0, cmdArg = 0;
  logic cmdAccept, errValid;
  logic [2:0] errCode, devMode;
  logic [23:0] bankState;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lpCmdTracker u_lpCmdTracker (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdRowTop(cmdRowTop), .cmdArg(cmdArg),
    .cmdAccept(cmdAccept), .errValid(errValid), .errCode(errCode),
    .devMode(devMode), .bankState(bankState)
  );

  function automatic int bk(input int b);
    return int'(bankState[b*3 +: 3]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input int b, input logic [1:0] rt,
                       input logic [1:0] ar);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdBank = 3'(b); cmdRowTop = rt; cmdArg = ar;
    @(posedge clk); #1;
    cmdValid = 0; cmdOp = NOP;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expOk(input string req);
    check({req, " accept"}, int'(cmdAccept), 1);
    check({req, " no error"}, int'(errValid), 0);
  endtask

  task automatic expErr(input string req, input int code);
    check({req, " error pulse"}, int'(errValid), 1);
    check({req, " error code"}, int'(errCode), code);
  endtask

  task automatic tReset;
    check("R1 accept low", int'(cmdAccept), 0);
    check("R1 error low", int'(errValid), 0);
    check("R1 code zero", int'(errCode), 0);
    check("R1 banks idle", int'(bankState), 0);
    check("R1 mode normal", int'(devMode), 0);
  endtask

  task automatic tActivate;
    issue(ACT, 2, 2'b00, 0); expOk("R2 act");
    check("R2 bank2 open", bk(2), OPEN);
    check("R2 bank3 idle", bk(3), IDLE);
    issue(ACT, 2, 2'b00, 0); expErr("R2 act open bank", 2);
  endtask

  task automatic tNotOpen;
    issue(RD, 5, 2'b00, 0); expErr("R3 rd idle bank", 1);
    issue(WRA, 6, 2'b00, 0); expErr("R3 wra idle bank", 1);
  endtask

  task automatic tBurst;
    issue(RD, 2, 2'b00, 0); expOk("R4 rd");
    check("R4 reading", bk(2), SRD);
    issue(PRE, 2, 2'b00, 0); expErr("R4 pre in burst", 3);
    waitCyc(2); check("R4 last burst cycle", bk(2), SRD);
    waitCyc(1); check("R4 burst done", bk(2), OPEN);
  endtask

  task automatic tAutoPre;
    issue(WRA, 2, 2'b00, 0); expOk("R5 wra");
    issue(PREA, 0, 2'b00, 0); expErr("R4 prea in burst", 3);
    waitCyc(2); check("R5 burst", bk(2), SWRA);
    waitCyc(1); check("R5 closing", bk(2), CLOSING);
    issue(ACT, 2, 2'b00, 0); expErr("R2 act closing bank", 2);
    check("R5 idle", bk(2), IDLE);
  endtask

  task automatic tHiRow;
    issue(ACT, 1, 2'b11, 0); expOk("R6 act hi row");
    check("R6 bank stays idle", bk(1), IDLE);
    issue(ACT, 1, 2'b01, 0); expOk("R6 act normal row");
    issue(WR, 1, 2'b11, 0); expOk("R6 wr hi row");
    check("R6 no burst", bk(1), OPEN);
  endtask

  task automatic tRefresh;
    issue(REF, 0, 0, 0); expErr("R7 ref with open bank", 2);
    issue(PRE, 1, 0, 0); expOk("R12 pre open");
    check("R12 bank1 idle", bk(1), IDLE);
    issue(PRE, 1, 0, 0); expOk("R12 pre idle");
    issue(REF, 0, 0, 0); expOk("R7 ref");
    check("R7 mode refresh", int'(devMode), 1);
    issue(ACT, 1, 0, 0); expErr("R7 act during refresh", 2);
    waitCyc(6); check("R7 still refresh", int'(devMode), 1);
    waitCyc(1); check("R7 refresh over", int'(devMode), 0);
  endtask

  task automatic tTrain;
    issue(MRW, 0, 0, 2'd1); expOk("R8 enter ca training");
    check("R8 mode ca", int'(devMode), 5);
    waitCyc(5); check("R8 held", int'(devMode), 5);
    issue(ACT, 0, 0, 0); expErr("R8 act in training", 4);
    issue(MRW, 0, 0, 2'd0); expOk("R8 exit");
    check("R8 normal", int'(devMode), 0);
    issue(MRW, 0, 0, 2'd2); check("R8 mode wl", int'(devMode), 6);
    issue(MRW, 0, 0, 2'd0); check("R8 wl exit", int'(devMode), 0);
  endtask

  task automatic tLowPower;
    issue(EXIT, 0, 0, 0); expErr("R9 exit in normal", 2);
    issue(ACT, 0, 0, 0); expOk("R9 act");
    issue(PD, 0, 0, 0); expOk("R9 pd with open bank");
    check("R9 mode pd", int'(devMode), 2);
    issue(RD, 0, 0, 0); expErr("R9 rd in pd", 2);
    issue(EXIT, 0, 0, 0); expOk("R9 exit pd");
    check("R9 bank kept", bk(0), OPEN);
    issue(SREF, 0, 0, 0); expErr("R7 sref open bank", 2);
    issue(PREA, 0, 0, 0); expOk("R12 prea");
    check("R12 all idle", int'(bankState), 0);
    issue(SREF, 0, 0, 0); check("R9 mode sref", int'(devMode), 3);
    issue(EXIT, 0, 0, 0); check("R9 sref exit", int'(devMode), 0);
    issue(DPD, 0, 0, 0); check("R9 mode dpd", int'(devMode), 4);
    issue(MRR, 0, 0, 0); expErr("R9 mrr in dpd", 2);
    issue(EXIT, 0, 0, 0); check("R9 dpd exit", int'(devMode), 0);
  endtask

  task automatic tResetCmd;
    issue(ACT, 3, 0, 0);
    issue(MRW, 0, 0, 2'd3); expErr("R10 reset with open bank", 2);
    issue(MRR, 0, 0, 0); expErr("R7 mrr with open bank", 2);
    issue(PRE, 3, 0, 0);
    issue(MRW, 0, 0, 2'd3); expOk("R10 reset accepted");
    check("R10 banks idle", int'(bankState), 0);
    check("R10 mode normal", int'(devMode), 0);
  endtask

  task automatic tResult;
    issue(NOP, 0, 0, 0); expOk("R11 nop");
    waitCyc(1);
    check("R11 no accept without cmd", int'(cmdAccept), 0);
    check("R11 no error without cmd", int'(errValid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; tReset;
    @(negedge clk); rstN = 1;
    waitCyc(1);
    tActivate; tNotOpen; tBurst; tAutoPre; tHiRow; tRefresh;
    tTrain; tLowPower; tResetCmd; tResult;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule